// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block keeps a 32-bit free-running counter and a 32-bit compare value. Each tick of a count-enable strobe advances the counter by one. When the counter reaches the compare value, the block latches a timer interrupt. The interrupt is driven onto one of eight interrupt lines. A 3-bit routing field chooses which line.

Software uses a single write port with a select bit to load either the counter or the compare value. It reads the counter back at any time. Writing the compare value is the only way to acknowledge the interrupt.

A halt input freezes the counter. While it is high, no new match can occur. A feature input decides whether a match also sets the architectural pending flag; the interrupt line is raised either way.

Top module: `cmp_timer_top`

## Requirements
- R1: After reset, `countOut` is 0, the compare value is 0, `irqLines` is all zero and `timerPending` is 0.
- R2: On a cycle with `tick` high and `haltCount` low and no counter write, `countOut` rises by one on the next cycle, wrapping from 0xFFFFFFFF to 0.
- R3: While `haltCount` is high, `countOut` keeps its value across ticks; after `haltCount` drops, counting continues from that held value.
- R4: A write with `wrEn` high and `wrSel` = 0 loads `wrData` into the counter on the next cycle, whether or not the counter is halted; it wins over a simultaneous tick.
- R5: When a tick makes the counter equal to the compare value, the interrupt is latched from the next cycle onward. `irqLines` then has exactly bit `routeSel` high, following `routeSel` as it changes, and stays asserted until a compare write.
- R6: A match sets `timerPending` only when `rev2En` is high in the match cycle; the interrupt line is raised regardless of `rev2En`.
- R7: A write with `wrEn` high and `wrSel` = 1 loads the compare value and clears both `irqLines` and `timerPending` on the next cycle. It takes priority over a match in the same cycle; that match is compared against the old compare value.
- R8: While `haltCount` is high, ticks produce no match interrupt even when the counter is one below the compare value.
- R9: A compare value below the current count is matched after the counter wraps through zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tick | input | 1 | Count-enable strobe |
| haltCount | input | 1 | Freezes the counter while high |
| rev2En | input | 1 | Enables setting of the pending flag on a match |
| routeSel | input | 3 | Index of the interrupt line to drive |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 counter, 1 compare |
| wrData | input | 32 | Write data |
| countOut | output | 32 | Current counter value |
| timerPending | output | 1 | Timer pending flag |
| irqLines | output | 8 | Interrupt lines, at most one high |

## Verification
The hardest case to reach is a compare write that lands in the same cycle as the tick that would produce a match. The bench reaches it by first placing the compare value. It then loads the counter one below that value and, in a single cycle, issues the tick together with a compare write. A wrap-around match is reached by loading the counter near all-ones instead of waiting 2^32 ticks. A behavioural reference model follows every cycle so that interrupt persistence and rerouting are checked continuously.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef struct packed {
    logic loadCount;
    logic loadCompare;
    logic incCount;
  } ctlStrobes_t;
endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] countQ,
  output logic             hitNext
);
  logic [WIDTH-1:0] compareQ;
  logic [WIDTH-1:0] countInc;

  assign countInc = countQ + WIDTH'(1);
  // true when an increment now would make count equal compare
  assign hitNext  = (countInc == compareQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobes.loadCount) begin
      countQ <= wrData;
    end else if (strobes.incCount) begin
      countQ <= countInc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compareQ <= '0;
    end else if (strobes.loadCompare) begin
      compareQ <= wrData;
    end
  end
endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        haltCount,
  input  logic        rev2En,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic        hitNext,
  output ctlStrobes_t strobes,
  output logic        irqFlag,
  output logic        pendFlag
);
  logic matchNow;

  always_comb begin
    strobes.loadCount   = wrEn && !wrSel;
    strobes.loadCompare = wrEn && wrSel;
    strobes.incCount    = tick && !haltCount && !strobes.loadCount;
  end

  assign matchNow = strobes.incCount && hitNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag  <= 1'b0;
      pendFlag <= 1'b0;
    end else if (strobes.loadCompare) begin
      irqFlag  <= 1'b0;
      pendFlag <= 1'b0;
    end else if (matchNow) begin
      irqFlag <= 1'b1;
      if (rev2En) pendFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
  import cmp_timer_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int NLINES = 8,
  localparam int SELW  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              haltCount,
  input  logic              rev2En,
  input  logic [SELW-1:0]   routeSel,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  countOut,
  output logic              timerPending,
  output logic [NLINES-1:0] irqLines
);
  ctlStrobes_t strobes;
  logic        hitNext;
  logic        irqFlag;

  cmp_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .haltCount(haltCount),
    .rev2En(rev2En), .wrEn(wrEn), .wrSel(wrSel), .hitNext(hitNext),
    .strobes(strobes), .irqFlag(irqFlag), .pendFlag(timerPending)
  );

  cmp_timer_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .countQ(countOut), .hitNext(hitNext)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_route
    assign irqLines[i] = irqFlag && (routeSel == SELW'(i));
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int WIDTH  = 32,
  parameter int NLINES = 8,
  parameter int SELW   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              haltCount,
  input logic              rev2En,
  input logic [SELW-1:0]   routeSel,
  input logic              wrEn,
  input logic              wrSel,
  input logic [WIDTH-1:0]  wrData,
  input logic [WIDTH-1:0]  countOut,
  input logic              timerPending,
  input logic [NLINES-1:0] irqLines
);
  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !haltCount && !(wrEn && !wrSel)) |=> countOut == $past(countOut) + WIDTH'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (haltCount && !(wrEn && !wrSel)) |=> countOut == $past(countOut));

  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> countOut == $past(wrData));

  p_one_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));

  p_pend_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerPending) |-> $past(rev2En));

  p_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> (irqLines == '0) && !timerPending);

  p_no_match_halt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (haltCount && irqLines == '0 && !(wrEn && !wrSel) && $stable(routeSel)) |=> $stable(irqLines));
endmodule

bind cmp_timer_top cmp_timer_chk #(.WIDTH(WIDTH), .NLINES(NLINES), .SELW(SELW)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .haltCount(haltCount), .rev2En(rev2En),
  .routeSel(routeSel), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .countOut(countOut), .timerPending(timerPending), .irqLines(irqLines)
);

// File: tb/tb_cmp_timer_top.sv
module tb_cmp_timer_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        haltCount = 1'b0;
  logic        rev2En = 1'b1;
  logic [2:0]  routeSel = 3'd0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] countOut;
  logic        timerPending;
  logic [7:0]  irqLines;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] mCount = '0;
  logic [31:0] mCompare = '0;
  bit          mFlag = 1'b0;
  bit          mPend = 1'b0;

  cmp_timer_top dut (
    .clk(clk), .rstN(rstN), .tick(tick), .haltCount(haltCount), .rev2En(rev2En),
    .routeSel(routeSel), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .countOut(countOut), .timerPending(timerPending), .irqLines(irqLines)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic checkAll(input string tag);
    logic [7:0] expIrq;
    expIrq = mFlag ? (8'd1 << routeSel) : 8'd0;
    checks++;
    if (countOut !== mCount) begin
      errors++;
      $display("FAIL %s count actual %h expected %h", tag, countOut, mCount);
    end
    checks++;
    if (irqLines !== expIrq) begin
      errors++;
      $display("FAIL %s irqLines actual %b expected %b", tag, irqLines, expIrq);
    end
    checks++;
    if (timerPending !== mPend) begin
      errors++;
      $display("FAIL %s pending actual %b expected %b", tag, timerPending, mPend);
    end
  endtask

  // drive one cycle at negedge, advance model at posedge, check at next negedge
  task automatic step(input string tag, input bit t, input bit w, input bit s,
                      input logic [31:0] d);
    bit match;
    tick = t; wrEn = w; wrSel = s; wrData = d;
    @(posedge clk);
    match = t && !haltCount && !(w && !s) && ((mCount + 32'd1) == mCompare);
    if (w && s) begin
      mCompare = d; mFlag = 1'b0; mPend = 1'b0;
    end else if (match) begin
      mFlag = 1'b1;
      if (rev2En) mPend = 1'b1;
    end
    if (w && !s) mCount = d;
    else if (t && !haltCount) mCount = mCount + 32'd1;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    checkAll(tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after reset");

    // R2 plain counting
    for (int i = 0; i < 5; i++) step("R2 increment", 1, 0, 0, 0);
    step("R2 idle no tick", 0, 0, 0, 0);

    // R5/R6 match with pending enabled, line 3
    routeSel = 3'd3;
    step("R7 set compare", 0, 1, 1, 32'd9);
    for (int i = 0; i < 6; i++) step("R5 approach match", 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R5 irq persists", 1, 0, 0, 0);
    routeSel = 3'd6;
    @(negedge clk);
    checkAll("R5 reroute");
    step("R7 compare ack", 0, 1, 1, 32'd20);

    // R6 match without pending
    rev2En = 1'b0;
    for (int i = 0; i < 9; i++) step("R6 no-pend match", 1, 0, 0, 0);
    step("R7 ack again", 0, 1, 1, 32'd100);
    rev2En = 1'b1;

    // R3/R8 halted counting, R4 write while halted
    haltCount = 1'b1;
    step("R4 write count halted", 0, 1, 0, 32'd99);
    for (int i = 0; i < 4; i++) step("R8 halted no match", 1, 0, 0, 0);
    step("R3 hold", 1, 0, 0, 0);
    haltCount = 1'b0;
    step("R3 resume", 1, 0, 0, 0);
    step("R7 ack after resume", 0, 1, 1, 32'd500);

    // R4 write wins over tick
    step("R4 write beats tick", 1, 1, 0, 32'd7);

    // R7 compare write with simultaneous match
    step("R7 place compare", 0, 1, 1, 32'd50);
    step("R4 load below compare", 0, 1, 0, 32'd49);
    step("R7 ack beats match", 1, 1, 1, 32'd50);
    step("R7 tick after", 1, 0, 0, 0);

    // R9 wrap-around match
    routeSel = 3'd7;
    step("R9 set compare low", 0, 1, 1, 32'd1);
    step("R9 load near top", 0, 1, 0, 32'hFFFF_FFFE);
    for (int i = 0; i < 4; i++) step("R9 R2 wrap", 1, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule